// File: doc/BRIEF.md
# Fetch PC Sequencer with Predicted Next Address and Redirects

The block produces the program counter for instruction fetch, one request per cycle. A small direct-mapped table of branch targets predicts where the next fetch goes. On a hit, the stored target is used. On a miss, the next sequential word is used. Each request carries the fetch PC, the predicted next PC, a training token, the two local epoch tags and a running sequence number. Whatever consumes the request compares the prediction against the real outcome later.

Two correction channels come back into the block. The first comes from the execute stage and the second from an earlier checking (decode) stage. The execute channel always wins. An incorrect execute message trains the table, takes its epoch into the local execute epoch and steers the PC to the corrected address. A decode message only redirects when it is marked incorrect and is tagged with the current execute epoch. In that case it loads the local decode epoch and the PC. A decode message never trains. Any cycle that redirects issues no fetch, so it leaves a bubble. The downstream ready signal gates all progress, including the taking of feedback.

Top module: `fetch_seq`

## Requirements
- R1: After reset, the fetch PC is 0. Both epochs are 0 and the sequence number is 0. Every table row is invalid, so the prediction for PC 0 is 4.
- R2: The table has 64 rows, indexed by PC bits [7:2]. A row hits only when it is valid and its stored full-address tag equals the PC. A hit predicts the stored target. A miss predicts PC+4.
- R3: The training token sent with each request equals the fetch PC of that request.
- R4: The table is written only by execute feedback marked incorrect. That write stores the token as the tag and the corrected address as the target, and it marks the row valid. Correct execute feedback and all decode feedback leave the table unchanged.
- R5: Execute feedback has priority. Execute feedback is accepted (ex_fb_ready_o=1) whenever fetch_ready_i=1. Decode feedback is accepted only when fetch_ready_i=1 and no execute feedback is valid.
- R6: When accepted execute feedback is marked incorrect, fetch_valid_o is 0 in that cycle. In the next cycle, the PC equals the corrected address and the execute epoch equals the message epoch. The sequence number does not change.
- R7: When accepted execute feedback is marked correct, a normal fetch takes place in the same cycle.
- R8: A decode redirect happens only when accepted decode feedback is marked incorrect and its execute epoch equals the local execute epoch. In that cycle, fetch_valid_o is 0. In the next cycle, the PC equals the corrected address and the decode epoch equals the message's decode epoch.
- R9: Accepted decode feedback that is marked correct, or that carries a stale execute epoch, has no effect. A normal fetch takes place and both epochs are unchanged.
- R10: In a normal fetch (fetch_valid_o=1), the next PC becomes the predicted next address and the sequence number increments by one.
- R11: If a training write and a lookup target the same row in the same cycle, the lookup uses the row contents from before the write.
- R12: While fetch_ready_i=0, no feedback is accepted, no request is valid, and the PC, epochs, sequence number and table hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ex_fb_valid_i | input | 1 | Execute feedback present |
| ex_fb_ready_o | output | 1 | Execute feedback accepted this cycle (when valid) |
| ex_fb_epoch_i | input | 2 | Execute epoch carried by the message |
| ex_fb_ok_i | input | 1 | 1 = prediction was correct |
| ex_fb_info_i | input | 32 | Training token returned with the message |
| ex_fb_addr_i | input | 32 | Corrected next address |
| dc_fb_valid_i | input | 1 | Decode feedback present |
| dc_fb_ready_o | output | 1 | Decode feedback accepted this cycle (when valid) |
| dc_fb_ex_epoch_i | input | 2 | Execute epoch seen by decode |
| dc_fb_dc_epoch_i | input | 2 | New decode epoch |
| dc_fb_ok_i | input | 1 | 1 = prediction was correct |
| dc_fb_addr_i | input | 32 | Corrected next address |
| fetch_ready_i | input | 1 | Downstream can take a request |
| fetch_valid_o | output | 1 | Fetch request issued |
| fetch_pc_o | output | 32 | Fetch PC |
| fetch_pred_o | output | 32 | Predicted next PC |
| fetch_info_o | output | 32 | Training token |
| fetch_ex_epoch_o | output | 2 | Local execute epoch |
| fetch_dc_epoch_o | output | 2 | Local decode epoch |
| fetch_seq_o | output | 16 | Request sequence number |

## Verification
A row that is trained wrongly, or a valid bit that is lost, shows up in fetch_pred_o on the next fetch whose PC maps to that row. A wrong next-PC choice or a wrong epoch register appears at fetch_pc_o or at the epoch outputs one cycle after the feedback is accepted. A wrong arbitration decision appears in the same cycle, either as a missing bubble on fetch_valid_o or as a wrong ready. The bench keeps its own table and registers and compares every output on every cycle, so each of these faults is caught at its first visible cycle.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  typedef enum logic [1:0] {
    ACT_FETCH    = 2'd0,
    ACT_EX_REDIR = 2'd1,
    ACT_DC_REDIR = 2'd2,
    ACT_STALL    = 2'd3
  } fetch_act_e;
endpackage

// File: rtl/fetch_btb.sv
module fetch_btb #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ROWS   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic [ADDR_W-1:0] lk_pred_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_pc_i,
  input  logic [ADDR_W-1:0] wr_tgt_i
);
  localparam int unsigned IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [ROWS-1:0]   valid_q;
  logic [ADDR_W-1:0] tag_q [ROWS];
  logic [ADDR_W-1:0] tgt_q [ROWS];
  logic [IDX_W-1:0]  lk_idx, wr_idx;
  logic              hit;

  assign lk_idx = lk_pc_i[2 +: IDX_W];
  assign wr_idx = wr_pc_i[2 +: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx] <= 1'b1;
  end

  // payload needs no reset: guarded by valid_q
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx] <= wr_pc_i;
      tgt_q[wr_idx] <= wr_tgt_i;
    end
  end

  // read is from current flops, so a same-cycle write is not seen
  assign hit       = valid_q[lk_idx] && (tag_q[lk_idx] == lk_pc_i);
  assign lk_pred_o = hit ? tgt_q[lk_idx] : lk_pc_i + ADDR_W'(4);

  // R4
  no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(valid_q));

  // R4
  write_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/fetch_arb.sv
module fetch_arb
  import fetch_seq_pkg::*;
#(
  parameter int unsigned EPOCH_W = 2
) (
  input  logic               go_i,
  input  logic               ex_valid_i,
  input  logic               ex_ok_i,
  input  logic               dc_valid_i,
  input  logic               dc_ok_i,
  input  logic [EPOCH_W-1:0] dc_ex_epoch_i,
  input  logic [EPOCH_W-1:0] cur_ex_epoch_i,
  output logic               ex_ready_o,
  output logic               dc_ready_o,
  output logic               train_o,
  output fetch_act_e         act_o
);
  assign ex_ready_o = go_i;
  assign dc_ready_o = go_i && !ex_valid_i;
  assign train_o    = go_i && ex_valid_i && !ex_ok_i;

  always_comb begin
    if (!go_i)                                   act_o = ACT_STALL;
    else if (ex_valid_i && !ex_ok_i)             act_o = ACT_EX_REDIR;
    else if (!ex_valid_i && dc_valid_i && !dc_ok_i &&
             dc_ex_epoch_i == cur_ex_epoch_i)    act_o = ACT_DC_REDIR;
    else                                         act_o = ACT_FETCH;
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ROWS    = 64,
  parameter int unsigned EPOCH_W = 2,
  parameter int unsigned SEQ_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ex_fb_valid_i,
  output logic               ex_fb_ready_o,
  input  logic [EPOCH_W-1:0] ex_fb_epoch_i,
  input  logic               ex_fb_ok_i,
  input  logic [ADDR_W-1:0]  ex_fb_info_i,
  input  logic [ADDR_W-1:0]  ex_fb_addr_i,
  input  logic               dc_fb_valid_i,
  output logic               dc_fb_ready_o,
  input  logic [EPOCH_W-1:0] dc_fb_ex_epoch_i,
  input  logic [EPOCH_W-1:0] dc_fb_dc_epoch_i,
  input  logic               dc_fb_ok_i,
  input  logic [ADDR_W-1:0]  dc_fb_addr_i,
  input  logic               fetch_ready_i,
  output logic               fetch_valid_o,
  output logic [ADDR_W-1:0]  fetch_pc_o,
  output logic [ADDR_W-1:0]  fetch_pred_o,
  output logic [ADDR_W-1:0]  fetch_info_o,
  output logic [EPOCH_W-1:0] fetch_ex_epoch_o,
  output logic [EPOCH_W-1:0] fetch_dc_epoch_o,
  output logic [SEQ_W-1:0]   fetch_seq_o
);
  logic [ADDR_W-1:0]  pc_q, pred;
  logic [EPOCH_W-1:0] ex_ep_q, dc_ep_q;
  logic [SEQ_W-1:0]   seq_q;
  logic               train;
  fetch_act_e         act;

  fetch_arb #(.EPOCH_W(EPOCH_W)) u_arb (
    .go_i          (fetch_ready_i),
    .ex_valid_i    (ex_fb_valid_i),
    .ex_ok_i       (ex_fb_ok_i),
    .dc_valid_i    (dc_fb_valid_i),
    .dc_ok_i       (dc_fb_ok_i),
    .dc_ex_epoch_i (dc_fb_ex_epoch_i),
    .cur_ex_epoch_i(ex_ep_q),
    .ex_ready_o    (ex_fb_ready_o),
    .dc_ready_o    (dc_fb_ready_o),
    .train_o       (train),
    .act_o         (act)
  );

  fetch_btb #(.ADDR_W(ADDR_W), .ROWS(ROWS)) u_btb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_pc_i  (pc_q),
    .lk_pred_o(pred),
    .wr_en_i  (train),
    .wr_pc_i  (ex_fb_info_i),
    .wr_tgt_i (ex_fb_addr_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      ex_ep_q <= '0;
      dc_ep_q <= '0;
      seq_q   <= '0;
    end else begin
      unique case (act)
        ACT_EX_REDIR: begin
          pc_q    <= ex_fb_addr_i;
          ex_ep_q <= ex_fb_epoch_i;
        end
        ACT_DC_REDIR: begin
          pc_q    <= dc_fb_addr_i;
          dc_ep_q <= dc_fb_dc_epoch_i;
        end
        ACT_FETCH: begin
          pc_q  <= pred;
          seq_q <= seq_q + SEQ_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign fetch_valid_o    = (act == ACT_FETCH);
  assign fetch_pc_o       = pc_q;
  assign fetch_pred_o     = pred;
  assign fetch_info_o     = pc_q;
  assign fetch_ex_epoch_o = ex_ep_q;
  assign fetch_dc_epoch_o = dc_ep_q;
  assign fetch_seq_o      = seq_q;

  // R6
  ex_redir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_ready_i && ex_fb_valid_i && !ex_fb_ok_i) |=>
      (fetch_pc_o == $past(ex_fb_addr_i)) && (fetch_ex_epoch_o == $past(ex_fb_epoch_i))
      && $stable(fetch_seq_o));

  // R10
  fetch_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |=> (fetch_pc_o == $past(fetch_pred_o))
      && (fetch_seq_o == $past(fetch_seq_o) + SEQ_W'(1)));

  // R12
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_ready_i |=> $stable(fetch_pc_o) && $stable(fetch_seq_o)
      && $stable(fetch_ex_epoch_o) && $stable(fetch_dc_epoch_o));

  // R9
  stale_dc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_fb_valid_i && dc_fb_ready_o && dc_fb_ex_epoch_i != fetch_ex_epoch_o) |=>
      $stable(fetch_dc_epoch_o) && $stable(fetch_ex_epoch_o));

  // R5
  ex_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_fb_valid_i |-> !dc_fb_ready_o);
endmodule

// File: tb/fetch_seq_tb.sv
`timescale 1ns/1ps
module fetch_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ex_fb_valid_i = 0, ex_fb_ok_i = 0;
  logic [1:0]  ex_fb_epoch_i = 0;
  logic [31:0] ex_fb_info_i = 0, ex_fb_addr_i = 0;
  logic        dc_fb_valid_i = 0, dc_fb_ok_i = 0;
  logic [1:0]  dc_fb_ex_epoch_i = 0, dc_fb_dc_epoch_i = 0;
  logic [31:0] dc_fb_addr_i = 0;
  logic        fetch_ready_i = 0;
  logic        ex_fb_ready_o, dc_fb_ready_o, fetch_valid_o;
  logic [31:0] fetch_pc_o, fetch_pred_o, fetch_info_o;
  logic [1:0]  fetch_ex_epoch_o, fetch_dc_epoch_o;
  logic [15:0] fetch_seq_o;

  always #5 clk_i = ~clk_i;

  fetch_seq u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_pc, m_tag [64], m_tgt [64];
  logic [1:0]  m_ex, m_dc;
  logic [15:0] m_seq;
  bit          m_v [64];

  function automatic logic [31:0] m_lookup(input logic [31:0] pc);
    int i = int'(pc[7:2]);
    return (m_v[i] && m_tag[i] == pc) ? m_tgt[i] : pc + 32'd4;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit rdy, input bit exv, input logic [1:0] exep, input bit exok,
                      input logic [31:0] exinfo, input logic [31:0] exaddr,
                      input bit dcv, input logic [1:0] dcex, input logic [1:0] dcdc,
                      input bit dcok, input logic [31:0] dcaddr);
    bit ex_red, dc_red, e_val;
    logic [31:0] e_pred;
    @(negedge clk_i);
    fetch_ready_i = rdy; ex_fb_valid_i = exv; ex_fb_epoch_i = exep; ex_fb_ok_i = exok;
    ex_fb_info_i = exinfo; ex_fb_addr_i = exaddr; dc_fb_valid_i = dcv;
    dc_fb_ex_epoch_i = dcex; dc_fb_dc_epoch_i = dcdc; dc_fb_ok_i = dcok; dc_fb_addr_i = dcaddr;
    #1;
    e_pred = m_lookup(m_pc);
    ex_red = rdy && exv && !exok;
    dc_red = rdy && !exv && dcv && !dcok && (dcex == m_ex);
    e_val  = rdy && !ex_red && !dc_red;
    chk(fetch_pc_o, m_pc, "R6/R8/R10 pc");
    chk(fetch_pred_o, e_pred, "R2/R4/R11 pred");
    chk(fetch_info_o, m_pc, "R3 info");
    chk({30'd0, fetch_ex_epoch_o}, {30'd0, m_ex}, "R6 ex_epoch");
    chk({30'd0, fetch_dc_epoch_o}, {30'd0, m_dc}, "R8/R9 dc_epoch");
    chk({16'd0, fetch_seq_o}, {16'd0, m_seq}, "R10 seq");
    chk({31'd0, fetch_valid_o}, {31'd0, e_val}, "R6/R7/R9/R12 valid");
    chk({30'd0, ex_fb_ready_o, dc_fb_ready_o}, {30'd0, rdy, rdy && !exv}, "R5 ready");
    if (ex_red) begin
      m_v[exinfo[7:2]] = 1; m_tag[exinfo[7:2]] = exinfo; m_tgt[exinfo[7:2]] = exaddr;
      m_pc = exaddr; m_ex = exep;
    end else if (dc_red) begin
      m_pc = dcaddr; m_dc = dcdc;
    end else if (e_val) begin
      m_pc = e_pred; m_seq = m_seq + 16'd1;
    end
  endtask

  function automatic logic [31:0] rnd_addr();
    return {23'd0, 7'($urandom_range(0, 127)), 2'b00};
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    m_pc = 0; m_ex = 0; m_dc = 0; m_seq = 0;
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(fetch_pc_o, 32'd0, "R1 pc");
    chk(fetch_pred_o, 32'd4, "R1 pred");
    chk({14'd0, fetch_ex_epoch_o, fetch_dc_epoch_o, fetch_seq_o}, 32'd0, "R1 epochs/seq");
    // R11: train row of current PC 0 while looking it up; old miss value expected
    step(1, 1, 2'd1, 0, 32'h0, 32'h40, 0, 0, 0, 0, 0);
    // back to 0 via redirect; R4 row now trained -> pred 0x40
    step(1, 1, 2'd1, 0, 32'h80, 32'h0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // alias at 0x100 shares row 0 but tag differs: R2 miss
    step(1, 1, 2'd2, 1, 32'h0, 32'h0, 0, 0, 0, 0, 0);        // R7 correct, no train
    step(1, 1, 2'd2, 0, 32'h200, 32'h100, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 stale decode redirect ignored; R8 matching one applied
    step(1, 0, 0, 0, 0, 0, 1, 2'd0, 2'd3, 0, 32'h44);
    step(1, 0, 0, 0, 0, 0, 1, 2'd2, 2'd3, 0, 32'h44);
    step(1, 0, 0, 0, 0, 0, 1, 2'd2, 2'd1, 1, 32'h88);        // R9 correct
    // R5 both present: execute wins; R12 stall
    step(1, 1, 2'd3, 0, 32'h44, 32'h10, 1, 2'd2, 2'd0, 0, 32'h20);
    step(0, 1, 2'd0, 0, 32'h10, 32'h30, 1, 2'd3, 2'd2, 0, 32'h50);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      bit exv = ($urandom_range(0, 99) < 20);
      bit dcv = ($urandom_range(0, 99) < 25);
      logic [31:0] info = ($urandom_range(0, 1) == 1) ? m_pc : rnd_addr();
      logic [1:0] dcex = ($urandom_range(0, 1) == 1) ? m_ex : 2'($urandom_range(0, 3));
      step($urandom_range(0, 99) < 85, exv, 2'($urandom_range(0, 3)), $urandom_range(0, 2) == 0,
           info, rnd_addr(), dcv, dcex, 2'($urandom_range(0, 3)),
           $urandom_range(0, 2) == 0, rnd_addr());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule